// File: doc/BRIEF.md
# Status register write protection unit

This unit decides whether a serial memory device may write to its array or to its status register. It holds three things: the write-enable latch, a lock bit that lets the hardware protect pin guard the status register, and a two-bit code that selects a protected range at the top of the address space. A command decoder drives it with one-cycle pulses: enable, disable, status write with its data byte, and end of a memory write. It also receives the protect pin level and the target address of the memory write in progress. The unit returns the status byte for readback and two permit signals.

Protection works in tiers. When the latch is clear, every write is refused. Completing a write clears the latch again. The range code fences off the upper quarter, the upper half or the whole array. The protect pin can lock the status register only when the lock bit is set. The pin level is captured on each chip-select falling edge, so a pin change during a transaction has no effect until the next one begins. Reset values stand in for the stored bits.

Top module: `wp_unit`

## Requirements
- R1: After reset the status byte reads 0x40 (lock 0, range code 00, latch 0), and both permits are low.
- R2: The status byte is {lock, 1, 0, 0, range[1:0], latch, 0} (bit 7 down to bit 0). Bits 6, 5, 4 and 0 keep their fixed values whatever data a status write carries.
- R3: An enable pulse (`wren_i`) sets the latch in the next cycle. A disable pulse (`wrdi_i`) clears it. If both arrive in the same cycle, the latch is cleared.
- R4: A permitted status write loads the lock bit from data bit 7 and the range code from data bits 3:2. It ignores data bit 1, and it clears the latch.
- R5: A memory-write-done pulse clears the latch.
- R6: Range code 00 protects nothing. Code 01 protects addresses whose two top bits are 11 (the top quarter). Code 10 protects addresses whose top bit is 1 (the top half). Code 11 protects every address.
- R7: While the latch is clear, neither permit is ever high, for any address.
- R8: With the latch set, the status write permit is low only when the lock bit is 1 and the captured pin level is 0. With the lock bit at 0, the pin has no effect.
- R9: The pin level is captured only on a `cs_fall_i` pulse and is 0 after reset. A pin change with no such pulse does not change the status write permit.
- R10: A refused status write leaves the whole status byte unchanged, including the latch.
- R11: The memory write permit follows `mem_addr_i` combinationally in the same cycle: it is high when the latch is set and the address is outside the protected range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Enable-writes command pulse |
| wrdi_i | input | 1 | Disable-writes command pulse |
| sr_wr_i | input | 1 | Status write command pulse |
| sr_data_i | input | 8 | Data byte of the status write |
| mem_done_i | input | 1 | Memory write completed pulse |
| cs_fall_i | input | 1 | Chip-select falling edge pulse |
| wp_ni | input | 1 | Hardware protect pin, active low |
| mem_addr_i | input | ADDR_W | Target address of the memory write |
| status_o | output | 8 | Status byte for readback |
| mem_wr_ok_o | output | 1 | Memory write permitted at `mem_addr_i` |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
A wrong latch value shows on status bit 1 in the cycle after the pulse that caused it, and on both permits at the same moment. A corrupted range code or lock bit shows at once on status bits 7 and 3:2. It then shows through the permit pattern when all addresses are swept under each range code. A pin capture taken at the wrong time shows only through the status write permit: it is set up by changing the pin between chip-select pulses and reading the permit before and after the next one.

// File: rtl/wp_unit_pkg.sv
package wp_unit_pkg;
  localparam logic [1:0] RANGE_NONE    = 2'b00;
  localparam logic [1:0] RANGE_QUARTER = 2'b01;
  localparam logic [1:0] RANGE_HALF    = 2'b10;
  localparam logic [1:0] RANGE_ALL     = 2'b11;

  localparam int LOCK_BIT  = 7;
  localparam int RANGE_LSB = 2;
  localparam int LATCH_BIT = 1;

  function automatic logic [7:0] pack_status(logic lock, logic [1:0] rng, logic latch);
    return {lock, 1'b1, 2'b00, rng, latch, 1'b0};
  endfunction
endpackage

// File: rtl/wp_enable_latch.sv
module wp_enable_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_o <= 1'b0;
    else if (clr_i)  en_o <= 1'b0;
    else if (set_i)  en_o <= 1'b1;
  end

  a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !en_o);
  a_r3_set_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> en_o);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(en_o));
endmodule

// File: rtl/wp_status_bits.sv
module wp_status_bits #(
  parameter logic       INIT_LOCK  = 1'b0,
  parameter logic [1:0] INIT_RANGE = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       cs_fall_i,
  input  logic       wp_ni,
  output logic       lock_o,
  output logic [1:0] range_o,
  output logic       pin_lat_o
);
  import wp_unit_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o  <= INIT_LOCK;
      range_o <= INIT_RANGE;
    end else if (load_i) begin
      lock_o  <= data_i[LOCK_BIT];
      range_o <= data_i[RANGE_LSB +: 2];
    end
  end

  // pin level sampled once per transaction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pin_lat_o <= 1'b0;
    else if (cs_fall_i) pin_lat_o <= wp_ni;
  end

  a_r9_pin_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall_i |=> $stable(pin_lat_o));
  a_r10_bits_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(lock_o) && $stable(range_o)));
endmodule

// File: rtl/wp_range_check.sv
module wp_range_check #(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        range_i,
  output logic              prot_o
);
  import wp_unit_pkg::*;

  localparam int TOP = ADDR_W - 1;

  always_comb begin
    case (range_i)
      RANGE_QUARTER: prot_o = &addr_i[TOP -: 2];
      RANGE_HALF:    prot_o = addr_i[TOP];
      RANGE_ALL:     prot_o = 1'b1;
      default:       prot_o = 1'b0;
    endcase
  end

  always_comb begin
    if (range_i == RANGE_NONE) a_r6_none_open: assert (!prot_o);
    if (addr_i == '0 && range_i != RANGE_ALL) a_r6_base_open: assert (!prot_o);
  end
endmodule

// File: rtl/wp_unit.sv
module wp_unit #(
  parameter int         ADDR_W     = 18,
  parameter logic       INIT_LOCK  = 1'b0,
  parameter logic [1:0] INIT_RANGE = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              mem_done_i,
  input  logic              cs_fall_i,
  input  logic              wp_ni,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic [7:0]        status_o,
  output logic              mem_wr_ok_o,
  output logic              sr_wr_ok_o
);
  import wp_unit_pkg::*;

  logic       en;
  logic       lock;
  logic [1:0] rng;
  logic       pin_lat;
  logic       prot;
  logic       sr_load;

  assign sr_wr_ok_o = en && !(lock && !pin_lat);
  assign sr_load    = sr_wr_i && sr_wr_ok_o;

  wp_enable_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wren_i),
    .clr_i  (wrdi_i || mem_done_i || sr_load),
    .en_o   (en)
  );

  wp_status_bits #(
    .INIT_LOCK  (INIT_LOCK),
    .INIT_RANGE (INIT_RANGE)
  ) u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sr_load),
    .data_i    (sr_data_i),
    .cs_fall_i (cs_fall_i),
    .wp_ni     (wp_ni),
    .lock_o    (lock),
    .range_o   (rng),
    .pin_lat_o (pin_lat)
  );

  wp_range_check #(.ADDR_W(ADDR_W)) u_range (
    .addr_i  (mem_addr_i),
    .range_i (rng),
    .prot_o  (prot)
  );

  assign mem_wr_ok_o = en && !prot;
  assign status_o    = pack_status(lock, rng, en);

  a_r7_mem_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_ok_o |-> status_o[LATCH_BIT]);
  a_r7_sr_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_ok_o |-> status_o[LATCH_BIT]);
  a_r6_all_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[RANGE_LSB +: 2] == RANGE_ALL) |-> !mem_wr_ok_o);
  a_r4_sr_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_i && sr_wr_ok_o) |=> !status_o[LATCH_BIT]);
  a_r5_done_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_done_i |=> !status_o[LATCH_BIT]);
  a_r10_refused_sr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_i && !sr_wr_ok_o && !wren_i && !wrdi_i && !mem_done_i) |=> $stable(status_o));
endmodule

// File: tb/wp_unit_test.sv
module wp_unit_test;
  localparam int AW = 6;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wren = 0, wrdi = 0, sr_wr = 0, done = 0, cs_fall = 0, wp_n = 0;
  logic [7:0]    sr_data = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    status;
  logic          mem_ok, sr_ok;
  int            checks = 0;
  int            fails = 0;

  always #5 clk = ~clk;

  wp_unit #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi),
    .sr_wr_i(sr_wr), .sr_data_i(sr_data), .mem_done_i(done),
    .cs_fall_i(cs_fall), .wp_ni(wp_n), .mem_addr_i(addr),
    .status_o(status), .mem_wr_ok_o(mem_ok), .sr_wr_ok_o(sr_ok)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic pulse(input bit a, input bit b, input bit s, input bit d, input bit c,
                       input logic [7:0] data);
    @(negedge clk);
    wren = a; wrdi = b; sr_wr = s; done = d; cs_fall = c; sr_data = data;
    @(negedge clk);
    wren = 0; wrdi = 0; sr_wr = 0; done = 0; cs_fall = 0;
  endtask

  function automatic bit prot_exp(input int rng, input int a);
    return (rng == 3) || (rng == 2 && a >= NA / 2) || (rng == 1 && a >= 3 * NA / 4);
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 8'h40);
    chk("R1 mem_ok", mem_ok, 0);
    chk("R1 sr_ok", sr_ok, 0);

    // R7: latch clear, every address refused
    for (int a = 0; a < NA; a++) begin
      addr = a[AW-1:0]; #1;
      chk("R7 mem_ok with latch clear", mem_ok, 0);
    end
    // R10: refused status write with latch clear
    pulse(0, 0, 1, 0, 0, 8'hFF);
    chk("R10 refused write latch clear", status, 8'h40);

    pulse(1, 0, 0, 0, 0, 8'h00);
    chk("R3 enable sets latch", status, 8'h42);
    chk("R8 lock 0 pin ignored", sr_ok, 1);

    pulse(0, 0, 1, 0, 0, 8'hFF);
    chk("R2 R4 status after FF write", status, 8'hCC);

    wp_n = 1;
    pulse(1, 0, 0, 0, 1, 8'h00);
    chk("R8 pin high permits", sr_ok, 1);
    @(negedge clk); wp_n = 0;
    @(negedge clk);
    chk("R9 pin change without cs fall", sr_ok, 1);
    pulse(0, 0, 0, 0, 1, 8'h00);
    chk("R8 lock with pin low", sr_ok, 0);
    pulse(0, 0, 1, 0, 0, 8'h00);
    chk("R10 refused write keeps byte", status, 8'hCE);

    pulse(0, 1, 0, 0, 0, 8'h00);
    chk("R3 disable clears latch", status, 8'hCC);
    pulse(1, 1, 0, 0, 0, 8'h00);
    chk("R3 disable wins over enable", status, 8'hCC);

    wp_n = 1;
    pulse(1, 0, 0, 0, 1, 8'h00);
    pulse(0, 0, 1, 0, 0, 8'h32);
    chk("R2 R4 fixed bits and data bit1", status, 8'h40);

    for (int r = 0; r < 4; r++) begin
      pulse(1, 0, 0, 0, 0, 8'h00);
      pulse(0, 0, 1, 0, 0, 8'(r << 2) | 8'h02);
      chk("R4 range loaded, latch cleared", status, 8'h40 | (r << 2));
      pulse(1, 0, 0, 0, 0, 8'h00);
      for (int a = 0; a < NA; a++) begin
        addr = a[AW-1:0]; #1;
        chk("R6 R11 range permit", mem_ok, prot_exp(r, a) ? 0 : 1);
      end
      pulse(0, 0, 0, 1, 0, 8'h00);
      chk("R5 done clears latch", status[1], 0);
      addr = '0; #1;
      chk("R7 mem_ok after done", mem_ok, 0);
    end

    // lock 1 then pin low: status locked, memory writes unaffected
    pulse(1, 0, 0, 0, 0, 8'h00);
    pulse(0, 0, 1, 0, 0, 8'h80);
    chk("R4 lock loaded", status, 8'hC0);
    wp_n = 0;
    pulse(1, 0, 0, 0, 1, 8'h00);
    chk("R8 lock pin low", sr_ok, 0);
    addr = '1; #1;
    chk("R8 memory open while locked", mem_ok, 1);
    wp_n = 1;
    @(negedge clk);
    chk("R9 no cs fall keeps lock", sr_ok, 0);
    pulse(0, 0, 0, 0, 1, 8'h00);
    chk("R9 cs fall captures pin", sr_ok, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule